// File: doc/BRIEF.md
# 16-bit Compare Timer

This block is a 16-bit up-counter with two output compare channels. Software reaches it over an 8-bit register bus. The counter and each compare register appear as a low/high byte pair. One shared staging byte makes every 16-bit transfer atomic: a high-byte write only loads the staging byte, and the following low-byte write commits both bytes together. A low-byte read returns the low byte and parks the high byte in the staging byte, so a later high-byte read returns a value that matches it.

On every timer tick (`tick_i`), each channel compares its register with the counter value before the increment. A match sets that channel's interrupt flag and updates its waveform pin according to a 2-bit action field. Software can fire a forced compare, which moves the pin only. A clear-on-compare option makes channel A's real match reset the counter instead of advancing it. Any software write to the counter hides compare matches on the next tick.

Top module: `tmr16_timer`

## Requirements
- R1: After reset, the counter, both compare registers, the staging byte, control and flags are zero, and `wave_o` and `irq_o` are low.
- R2: A write to a high-byte address (counter 0x5, compare A 0x7, compare B 0x9) only loads the shared staging byte and leaves its target unchanged. A write to the matching low-byte address (0x4, 0x6, 0x8) loads {staging, data} into the 16-bit target in one step, and any of the three high addresses can feed any target.
- R3: A read of a low-byte address returns the low byte and copies the target's high byte into the staging byte. A read of any high-byte address returns the staging byte.
- R4: The counter rises by one on each clock edge with `tick_i` high, wraps from 0xFFFF to 0x0000, and holds when `tick_i` is low.
- R5: On a tick that is not blocked, a channel whose compare value equals the counter value before the increment sets its flag. Flags read at address 0x2 (bit 0 = A, bit 1 = B) and drive `irq_o`.
- R6: Control address 0x0 holds the channel actions: bits [2:1] for A and bits [4:3] for B. On a match the pin action is 00 = unchanged, 01 = toggle, 10 = drive low, 11 = drive high.
- R7: Writing a one to bit 0 (A) or bit 1 (B) of address 0x1 applies that channel's action to its pin. It sets no flag and never clears the counter. Address 0x1 always reads as zero.
- R8: Writing a one to a flag bit at address 0x2 clears that flag, and writing a zero leaves it unchanged.
- R9: After any counter write, the next tick performs no compare on either channel, but the counter still advances.
- R10: With control bit 0 set, a real channel A match clears the counter to zero on that tick instead of incrementing it.
- R11: A counter commit on the same edge as a tick loads the written value, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable, one count per high cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the strobe cycle, zero when idle |
| wave_o | output | N_CH | Compare waveform pins, bit 0 = channel A |
| irq_o | output | N_CH | Compare interrupt flags, bit 0 = channel A |

## Verification
The bench builds the block with its defaults: 8-bit bus, 16-bit counter and two channels. The counter is preloaded through the byte pair, so the 0xFFFF wrap and matches a few ticks ahead of the preload take only a few cycles. Preloading also starts each match test with the blocked tick that follows a counter write, so compare blocking is exercised along with the match itself. Same-edge collisions between a counter write and a tick are driven directly.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef logic [3:0] reg_addr_t;

  localparam reg_addr_t A_CTRL  = 4'h0;
  localparam reg_addr_t A_FORCE = 4'h1;
  localparam reg_addr_t A_FLAG  = 4'h2;
  // byte pairs: counter, then each compare, low byte at even address
  localparam reg_addr_t A_WIDE  = 4'h4;

  typedef enum logic [1:0] {
    OC_KEEP   = 2'b00,
    OC_TOGGLE = 2'b01,
    OC_LOW    = 2'b10,
    OC_HIGH   = 2'b11
  } oc_mode_e;

  function automatic logic oc_apply(oc_mode_e m, logic cur);
    case (m)
      OC_TOGGLE: return ~cur;
      OC_LOW:    return 1'b0;
      OC_HIGH:   return 1'b1;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_CH   = 2,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  reg_addr_t         addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_i [N_CH],
  input  logic [N_CH-1:0]   flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cnt_wr_o,
  output logic [N_CH-1:0]   cmp_wr_o,
  output logic [CNT_W-1:0]  wide_o,
  output logic [N_CH-1:0]   force_o,
  output logic [N_CH-1:0]   flag_clr_o,
  output logic              ctc_o,
  output oc_mode_e          mode_o [N_CH]
);

  localparam int unsigned N_WIDE = N_CH + 1;

  logic [DATA_W-1:0] temp_q, temp_d;
  logic              temp_ld;
  logic [N_WIDE-1:0] commit;
  logic [CNT_W-1:0]  wide_val [N_WIDE];
  logic              ctc_q;
  oc_mode_e          mode_q [N_CH];
  logic [DATA_W-1:0] ctrl_rd;

  assign wide_val[0] = cnt_i;
  for (genvar g = 0; g < N_CH; g++) begin : g_wide
    assign wide_val[g+1] = cmp_i[g];
  end

  assign cnt_wr_o = commit[0];
  assign cmp_wr_o = commit[N_WIDE-1:1];
  assign wide_o   = {temp_q, wdata_i};
  assign ctc_o    = ctc_q;
  assign mode_o   = mode_q;

  always_comb begin
    ctrl_rd    = '0;
    ctrl_rd[0] = ctc_q;
    for (int k = 0; k < N_CH; k++) ctrl_rd[2*k+1 +: 2] = mode_q[k];
  end

  always_comb begin
    commit     = '0;
    temp_ld    = 1'b0;
    temp_d     = temp_q;
    rdata_o    = '0;
    force_o    = '0;
    flag_clr_o = '0;
    for (int k = 0; k < N_WIDE; k++) begin
      if (addr_i == reg_addr_t'(A_WIDE + 2*k)) begin
        commit[k] = wr_i;
        if (rd_i) begin
          rdata_o = wide_val[k][DATA_W-1:0];
          temp_ld = 1'b1;
          temp_d  = wide_val[k][CNT_W-1:DATA_W];
        end
      end
      if (addr_i == reg_addr_t'(A_WIDE + 2*k + 1)) begin
        if (wr_i) begin
          temp_ld = 1'b1;
          temp_d  = wdata_i;
        end
        if (rd_i) rdata_o = temp_q;
      end
    end
    if (addr_i == A_CTRL && rd_i) rdata_o = ctrl_rd;
    if (addr_i == A_FLAG && rd_i) rdata_o = DATA_W'(flag_i);
    if (addr_i == A_FORCE && wr_i) force_o    = wdata_i[N_CH-1:0];
    if (addr_i == A_FLAG  && wr_i) flag_clr_o = wdata_i[N_CH-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q <= '0;
      ctc_q  <= 1'b0;
      for (int k = 0; k < N_CH; k++) mode_q[k] <= OC_KEEP;
    end else begin
      if (temp_ld) temp_q <= temp_d;
      if (wr_i && addr_i == A_CTRL) begin
        ctc_q <= wdata_i[0];
        for (int k = 0; k < N_CH; k++) mode_q[k] <= oc_mode_e'(wdata_i[2*k+1 +: 2]);
      end
    end
  end

  // force address has no storage behind it
  p_force_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_FORCE) |-> rdata_o == '0);

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cmp_en_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             blk_q;

  assign cnt_o    = cnt_q;
  assign cmp_en_o = tick_i & ~blk_q & ~wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
      blk_q <= 1'b1;
    end else if (tick_i) begin
      blk_q <= 1'b0;
      cnt_q <= clr_i ? '0 : cnt_q + CNT_W'(1);
    end
  end

  p_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && !clr_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
  p_ctc_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && clr_i && !wr_i) |=> cnt_q == '0);
  p_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> !cmp_en_o);

endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cmp_en_i,
  input  logic             force_i,
  input  logic             flag_clr_i,
  input  oc_mode_e         mode_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_o,
  output logic             flag_o,
  output logic             wave_o
);

  logic [CNT_W-1:0] cmp_q;
  logic             flag_q, wave_q;

  assign cmp_o   = cmp_q;
  assign match_o = cmp_en_i && (cnt_i == cmp_q);
  assign flag_o  = flag_q;
  assign wave_o  = wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (cmp_wr_i) cmp_q <= wdata_i;
      // set beats clear
      if (match_o)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (match_o || force_i) wave_q <= oc_apply(mode_i, wave_q);
    end
  end

  p_flag_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(match_o));
  p_wave_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wave_q) |-> $past(match_o || force_i));
  p_force_noflag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !match_o && !flag_q) |=> !flag_q);

endmodule

// File: rtl/tmr16_timer.sv
module tmr16_timer
  import tmr16_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_CH   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [3:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [N_CH-1:0]   wave_o,
  output logic [N_CH-1:0]   irq_o
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt, wide;
  logic [CNT_W-1:0] cmp_val [N_CH];
  logic             cnt_wr, cmp_en, ctc;
  logic [N_CH-1:0]  cmp_wr, force_s, flag_clr, match, flag;
  oc_mode_e         mode [N_CH];

  tmr16_regs #(.DATA_W(DATA_W), .N_CH(N_CH)) i_regs (
    .clk_i, .rst_ni,
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .cnt_i      (cnt),
    .cmp_i      (cmp_val),
    .flag_i     (flag),
    .rdata_o    (bus_rdata_o),
    .cnt_wr_o   (cnt_wr),
    .cmp_wr_o   (cmp_wr),
    .wide_o     (wide),
    .force_o    (force_s),
    .flag_clr_o (flag_clr),
    .ctc_o      (ctc),
    .mode_o     (mode)
  );

  tmr16_count #(.CNT_W(CNT_W)) i_count (
    .clk_i, .rst_ni,
    .tick_i,
    .wr_i     (cnt_wr),
    .wdata_i  (wide),
    .clr_i    (ctc & match[0]),
    .cnt_o    (cnt),
    .cmp_en_o (cmp_en)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr16_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i, .rst_ni,
      .cmp_wr_i   (cmp_wr[g]),
      .wdata_i    (wide),
      .cnt_i      (cnt),
      .cmp_en_i   (cmp_en),
      .force_i    (force_s[g]),
      .flag_clr_i (flag_clr[g]),
      .mode_i     (mode[g]),
      .cmp_o      (cmp_val[g]),
      .match_o    (match[g]),
      .flag_o     (flag[g]),
      .wave_o     (wave_o[g])
    );
  end

  assign irq_o = flag;

endmodule

// File: tb/test_tmr16_timer.sv
module test_tmr16_timer;

  localparam logic [3:0] CTRL = 4'h0, FRC = 4'h1, FLG = 4'h2;
  localparam logic [3:0] CNT = 4'h4, CMA = 4'h6, CMB = 4'h8;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] wave, irq;
  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  tmr16_timer i_tmr16_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .wave_o(wave), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bw16(input logic [3:0] a, input logic [15:0] v);
    bw(a + 4'h1, v[15:8]); bw(a, v[7:0]);
  endtask

  task automatic br16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    br(a, lo); br(a + 4'h1, hi); v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    logic [7:0]  b;
    br16(CNT, v); chk("R1 counter", v, 16'h0);
    br16(CMA, v); chk("R1 compare A", v, 16'h0);
    br(FLG, b);   chk("R1 flags", b, 8'h0);
    br(CTRL, b);  chk("R1 control", b, 8'h0);
    chk("R1 pins", {wave, irq}, 4'h0);
  endtask

  task automatic t_atomic;
    logic [15:0] v;
    logic [7:0]  b;
    bw(CNT + 4'h1, 8'h12);
    br16(CNT, v); chk("R2 high write alone", v, 16'h0);
    bw16(CNT, 16'h1234);
    bw(CNT + 4'h1, 8'h77);
    br(CNT, b);         chk("R3 low read", b, 8'h34);
    br(CNT + 4'h1, b);  chk("R3 high from staging", b, 8'h12);
    bw(CMA + 4'h1, 8'hAB); bw(CMB, 8'hCD);
    br16(CMB, v); chk("R2 shared staging", v, 16'hABCD);
    br16(CMA, v); chk("R2 other target untouched", v, 16'h0);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    bw16(CMB, 16'h0);
    bw16(CNT, 16'hFFFE);
    ticks(2);
    br16(CNT, v); chk("R4 wrap", v, 16'h0);
    ticks(3);
    @(negedge clk);
    br16(CNT, v); chk("R4 increment", v, 16'h3);
    repeat (4) @(negedge clk);
    br16(CNT, v); chk("R4 hold without tick", v, 16'h3);
  endtask

  task automatic t_match;
    logic [15:0] v;
    logic [7:0]  b;
    bw(FLG, 8'h3);
    bw(CTRL, 8'h1A);  // A toggle, B high
    bw16(CMA, 16'd5); bw16(CMB, 16'd6); bw16(CNT, 16'd3);
    ticks(2);
    chk("R5 no match yet", irq, 2'b00);
    ticks(1);
    chk("R5 A match flag", irq, 2'b01);
    chk("R6 A toggle", wave, 2'b01);
    ticks(1);
    chk("R6 B drive high", wave, 2'b11);
    br(FLG, b); chk("R5 flag readback", b, 8'h3);
    br16(CNT, v); chk("R4 count after matches", v, 16'd7);
  endtask

  task automatic t_w1c;
    bw(FLG, 8'h0); chk("R8 zero keeps", irq, 2'b11);
    bw(FLG, 8'h1); chk("R8 clear A", irq, 2'b10);
    bw(FLG, 8'h2); chk("R8 clear B", irq, 2'b00);
  endtask

  task automatic t_block;
    logic [15:0] v;
    bw16(CNT, 16'd5);
    ticks(1);
    chk("R9 blocked flag", irq, 2'b00);
    chk("R9 blocked pin", wave, 2'b11);
    br16(CNT, v); chk("R9 still counts", v, 16'd6);
  endtask

  task automatic t_force;
    logic [15:0] v;
    logic [7:0]  b;
    bw(CTRL, 8'h0C);  // A low, B toggle
    bw(FRC, 8'h3);
    chk("R7 forced pins", wave, 2'b00);
    chk("R7 no flag", irq, 2'b00);
    br(FRC, b); chk("R7 reads zero", b, 8'h0);
    br16(CNT, v); chk("R7 counter untouched", v, 16'd6);
  endtask

  task automatic t_ctc;
    logic [15:0] v;
    bw(CTRL, 8'h07);  // clear on A, A high
    bw16(CMA, 16'd4); bw16(CNT, 16'd2);
    ticks(3);
    br16(CNT, v); chk("R10 cleared", v, 16'd0);
    chk("R10 A flag", irq, 2'b01);
    chk("R6 A drive high", wave, 2'b01);
    bw(FLG, 8'h3);
    bw16(CNT, 16'd4);
    bw(FRC, 8'h1);
    br16(CNT, v); chk("R7 force skips clear", v, 16'd4);
    chk("R7 force no flag in clear mode", irq, 2'b00);
  endtask

  task automatic t_keep_and_collide;
    logic [15:0] v;
    bw(CTRL, 8'h00);
    bw16(CNT, 16'd3);
    ticks(2);
    chk("R6 mode 00 flag", irq, 2'b01);
    chk("R6 mode 00 pin unchanged", wave, 2'b01);
    bw(CNT + 4'h1, 8'h00);
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = CNT; wdata = 8'h40;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    br16(CNT, v); chk("R11 write beats tick", v, 16'h0040);
  endtask

  initial begin
    #(8 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_atomic;
    t_wrap;
    t_match;
    t_w1c;
    t_block;
    t_force;
    t_ctc;
    t_keep_and_collide;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule